// File: doc/BRIEF.md
# FIFO Level and Error Interrupt Controller

This block keeps occupancy counts for a transmit queue and a receive queue of a serial port and turns queue events into sticky, maskable interrupt flags. The queue storage sits elsewhere. This block only sees the push, pop and flush strobes of each queue. From those it keeps an element count plus empty and full indications for each side. It also accepts single-cycle error pulses from the receiver: a framing fault and a parity fault. It detects a receive overrun by itself, when a byte arrives while the receive queue is full and nothing leaves it. That byte is dropped.

Three level events are watched. The receive count climbing to a programmable threshold or beyond is one. The transmit count arriving at exactly one entry is another. The transmit count falling to half the queue depth or below is the third. Each level event latches its flag only on the cycle its condition turns true, so software can clear a flag while the condition still holds. Every flag stays set until software writes a one to its bit. A single interrupt line is the OR of every flag gated by its enable bit.

The flag vector is seven bits wide with these positions:

| Bit | Event |
|-----|-------|
| 0 | framing fault |
| 1 | parity fault |
| 2 | reserved, always 0 |
| 3 | receive overrun |
| 4 | receive level reached |
| 5 | transmit down to one entry |
| 6 | transmit at half depth or below |

The enable vector uses the same positions.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: Each count is a 4-bit value in the range 0 to DEPTH (default 8).
  - An accepted push adds one and an accepted pop removes one. An accepted push together with an accepted pop leaves the count unchanged.
  - A pop on an empty queue is ignored.
  - A push on a full queue is ignored unless a pop is accepted in the same cycle.
  - The count output changes at the clock edge that samples the strobe.
- R2: The empty output is 1 exactly when the count is 0. The full output is 1 exactly when the count equals DEPTH.
- R3: A flush sets that queue's count to 0 at the next edge. A flush takes priority over a push or pop in the same cycle.
- R4: A receive push while the receive queue is full, with no accepted receive pop and no receive flush, leaves the count unchanged. It sets flag bit 3 at the same edge.
- R5: A framing-fault pulse sets flag bit 0 and a parity-fault pulse sets flag bit 1, both at the next edge. Flag bit 2 always reads 0.
- R6: Flag bit 4 sets one edge after the receive count changes from below the 4-bit threshold to at or above it. It does not set again while the count stays at or above the threshold.
- R7: Flag bit 5 sets one edge after the transmit count becomes exactly 1 from any other value.
- R8: Flag bit 6 sets one edge after the transmit count drops from above DEPTH/2 to DEPTH/2 or below.
- R9: Flags are sticky. A clear strobe removes the flags whose bits are 1 in the clear data. Bits that are 0 in the clear data keep their value.
- R10: If a flag's set event and its clear arrive in the same cycle, the flag ends up set.
- R11: The interrupt output is the OR over all bits of (flags AND enable). It follows the flags and enables combinationally.
- R12: After reset, all flags are 0, both counts are 0 and the interrupt output is 0.
  - Level conditions that are already true at reset do not set their flags. This covers the transmit half condition and a receive threshold of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txPush | input | 1 | Transmit queue write strobe |
| txPop | input | 1 | Transmit queue read strobe |
| txFlush | input | 1 | Empty the transmit queue |
| rxPush | input | 1 | Receive queue write strobe |
| rxPop | input | 1 | Receive queue read strobe |
| rxFlush | input | 1 | Empty the receive queue |
| frameErr | input | 1 | Receiver framing fault pulse |
| parityErr | input | 1 | Receiver parity fault pulse |
| rxThresh | input | 4 | Receive level threshold |
| irqEn | input | 7 | Per-flag enable, same bit positions as the flags |
| clrWrite | input | 1 | Clear strobe for the flags |
| clrData | input | 7 | Flags to clear, one bit per flag |
| txCount | output | 4 | Transmit queue element count |
| rxCount | output | 4 | Receive queue element count |
| txEmpty | output | 1 | Transmit queue empty |
| txFull | output | 1 | Transmit queue full |
| rxEmpty | output | 1 | Receive queue empty |
| rxFull | output | 1 | Receive queue full |
| irqFlags | output | 7 | Sticky interrupt flags |
| irq | output | 1 | Combined interrupt |

## Verification
The checker watches every cycle for these properties:
- the counts stay within range;
- full and empty agree with the counts;
- a flush always zeroes a count;
- an overrun both latches bit 3 and freezes the count;
- the reserved bit stays 0;
- flags stay set until cleared, and an error pulse wins against a clear in the same cycle;
- a fully masked enable vector silences the interrupt.

The edge-only behaviour of the three level flags depends on the history of the counts. Only the bench's scenarios show it:
- the flags set once on crossing;
- they do not set again while the condition holds;
- they stay quiet at reset.

The bench scenarios also show the ignored push and pop cases and the gating of the interrupt by single enable bits.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int FLAG_W       = 7;
  localparam int FLAG_FRAME   = 0;
  localparam int FLAG_PARITY  = 1;
  localparam int FLAG_RSVD    = 2;
  localparam int FLAG_OVERRUN = 3;
  localparam int FLAG_RXLVL   = 4;
  localparam int FLAG_TXONE   = 5;
  localparam int FLAG_TXHALF  = 6;

  // Accepted queue operations decided by the control unit
  typedef struct packed {
    logic txInc;
    logic txDec;
    logic txClr;
    logic rxInc;
    logic rxDec;
    logic rxClr;
    logic overrun;
  } fifoStrobes_t;
endpackage

// File: rtl/fifo_level_counter.sv
module fifo_level_counter #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inc,
  input  logic             dec,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [CNT_W-1:0] countQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (clr) begin
      countQ <= '0;
    end else if (inc && !dec) begin
      countQ <= countQ + 1'b1;
    end else if (dec && !inc) begin
      countQ <= countQ - 1'b1;
    end
  end

  assign count = countQ;
  assign empty = (countQ == '0);
  assign full  = (countQ == CNT_MAX);
endmodule

// File: rtl/fifo_irq_datapath.sv
module fifo_irq_datapath
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobes_t     strobes,
  output logic [CNT_W-1:0] txCount,
  output logic [CNT_W-1:0] rxCount,
  output logic             txEmpty,
  output logic             txFull,
  output logic             rxEmpty,
  output logic             rxFull
);
  fifo_level_counter #(.DEPTH(DEPTH)) u_txLevel (
    .clk  (clk),
    .rstN (rstN),
    .inc  (strobes.txInc),
    .dec  (strobes.txDec),
    .clr  (strobes.txClr),
    .count(txCount),
    .empty(txEmpty),
    .full (txFull)
  );

  fifo_level_counter #(.DEPTH(DEPTH)) u_rxLevel (
    .clk  (clk),
    .rstN (rstN),
    .inc  (strobes.rxInc),
    .dec  (strobes.rxDec),
    .clr  (strobes.rxClr),
    .count(rxCount),
    .empty(rxEmpty),
    .full (rxFull)
  );
endmodule

// File: rtl/fifo_irq_control.sv
module fifo_irq_control
  import fifo_irq_pkg::*;
(
  input  logic         txPush,
  input  logic         txPop,
  input  logic         txFlush,
  input  logic         rxPush,
  input  logic         rxPop,
  input  logic         rxFlush,
  input  logic         txEmpty,
  input  logic         txFull,
  input  logic         rxEmpty,
  input  logic         rxFull,
  output fifoStrobes_t strobes
);
  logic txPopOk;
  logic rxPopOk;

  always_comb begin
    txPopOk = txPop && !txEmpty;
    rxPopOk = rxPop && !rxEmpty;

    strobes         = '0;
    strobes.txClr   = txFlush;
    strobes.rxClr   = rxFlush;
    strobes.txDec   = txPopOk;
    strobes.rxDec   = rxPopOk;
    // A push on a full queue is accepted only when a pop makes room
    strobes.txInc   = txPush && (!txFull || txPopOk);
    strobes.rxInc   = rxPush && (!rxFull || rxPopOk);
    strobes.overrun = rxPush && rxFull && !rxPopOk && !rxFlush;
  end
endmodule

// File: rtl/fifo_irq_flags.sv
module fifo_irq_flags
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int THRESH_W = 4,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int CMP_W   = (CNT_W > THRESH_W) ? CNT_W : THRESH_W,
  localparam int HALF    = DEPTH / 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CNT_W-1:0]    txCount,
  input  logic [CNT_W-1:0]    rxCount,
  input  logic [THRESH_W-1:0] rxThresh,
  input  logic                frameErr,
  input  logic                parityErr,
  input  logic                overrun,
  input  logic [FLAG_W-1:0]   irqEn,
  input  logic                clrWrite,
  input  logic [FLAG_W-1:0]   clrData,
  output logic [FLAG_W-1:0]   flags,
  output logic                irq
);
  localparam int LVL_N = 3;

  logic [LVL_N-1:0]  levelNow;
  logic [LVL_N-1:0]  levelPrev;
  logic [LVL_N-1:0]  levelRise;
  logic [FLAG_W-1:0] flagsQ;
  logic [FLAG_W-1:0] setVec;
  logic [FLAG_W-1:0] clrVec;
  logic [FLAG_W-1:0] flagsNext;

  always_comb begin
    levelNow[0] = CMP_W'(rxCount) >= CMP_W'(rxThresh);
    levelNow[1] = (txCount == CNT_W'(1));
    levelNow[2] = (txCount <= CNT_W'(HALF));
  end

  assign levelRise = levelNow & ~levelPrev;

  // Previous-state reset to ones so conditions true at reset raise nothing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelPrev <= '1;
    end else begin
      levelPrev <= levelNow;
    end
  end

  always_comb begin
    setVec               = '0;
    setVec[FLAG_FRAME]   = frameErr;
    setVec[FLAG_PARITY]  = parityErr;
    setVec[FLAG_OVERRUN] = overrun;
    setVec[FLAG_RXLVL]   = levelRise[0];
    setVec[FLAG_TXONE]   = levelRise[1];
    setVec[FLAG_TXHALF]  = levelRise[2];
    clrVec               = clrWrite ? clrData : '0;
    flagsNext            = (flagsQ & ~clrVec) | setVec;
    flagsNext[FLAG_RSVD] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ <= '0;
    end else begin
      flagsQ <= flagsNext;
    end
  end

  assign flags = flagsQ;
  assign irq   = |(flagsQ & irqEn);
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int THRESH_W = 4,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                txPush,
  input  logic                txPop,
  input  logic                txFlush,
  input  logic                rxPush,
  input  logic                rxPop,
  input  logic                rxFlush,
  input  logic                frameErr,
  input  logic                parityErr,
  input  logic [THRESH_W-1:0] rxThresh,
  input  logic [FLAG_W-1:0]   irqEn,
  input  logic                clrWrite,
  input  logic [FLAG_W-1:0]   clrData,
  output logic [CNT_W-1:0]    txCount,
  output logic [CNT_W-1:0]    rxCount,
  output logic                txEmpty,
  output logic                txFull,
  output logic                rxEmpty,
  output logic                rxFull,
  output logic [FLAG_W-1:0]   irqFlags,
  output logic                irq
);
  fifoStrobes_t strobes;

  fifo_irq_control u_control (
    .txPush (txPush),
    .txPop  (txPop),
    .txFlush(txFlush),
    .rxPush (rxPush),
    .rxPop  (rxPop),
    .rxFlush(rxFlush),
    .txEmpty(txEmpty),
    .txFull (txFull),
    .rxEmpty(rxEmpty),
    .rxFull (rxFull),
    .strobes(strobes)
  );

  fifo_irq_datapath #(.DEPTH(DEPTH)) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .txCount(txCount),
    .rxCount(rxCount),
    .txEmpty(txEmpty),
    .txFull (txFull),
    .rxEmpty(rxEmpty),
    .rxFull (rxFull)
  );

  fifo_irq_flags #(.DEPTH(DEPTH), .THRESH_W(THRESH_W)) u_flags (
    .clk      (clk),
    .rstN     (rstN),
    .txCount  (txCount),
    .rxCount  (rxCount),
    .rxThresh (rxThresh),
    .frameErr (frameErr),
    .parityErr(parityErr),
    .overrun  (strobes.overrun),
    .irqEn    (irqEn),
    .clrWrite (clrWrite),
    .clrData  (clrData),
    .flags    (irqFlags),
    .irq      (irq)
  );
endmodule

// File: rtl/fifo_irq_checker.sv
module fifo_irq_checker
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              txFlush,
  input logic              rxPush,
  input logic              rxPop,
  input logic              rxFlush,
  input logic              frameErr,
  input logic [FLAG_W-1:0] irqEn,
  input logic              clrWrite,
  input logic [FLAG_W-1:0] clrData,
  input logic [CNT_W-1:0]  txCount,
  input logic [CNT_W-1:0]  rxCount,
  input logic              txFull,
  input logic              txEmpty,
  input logic              rxFull,
  input logic [FLAG_W-1:0] irqFlags,
  input logic              irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= CNT_MAX) && (rxCount <= CNT_MAX)); // R1

  AST_FULL_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    !(txFull && txEmpty) && (rxFull == (rxCount == CNT_MAX))); // R2

  AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    txFlush |=> (txCount == '0)); // R3

  AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && rxFull && !rxPop && !rxFlush) |=> (irqFlags[FLAG_OVERRUN] && rxFull)); // R4

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !irqFlags[FLAG_RSVD]); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlags[FLAG_FRAME] && !(clrWrite && clrData[FLAG_FRAME])) |=> irqFlags[FLAG_FRAME]); // R9

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> irqFlags[FLAG_FRAME]); // R10

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (irqEn == '0) |-> !irq); // R11
endmodule

bind fifo_irq_ctrl fifo_irq_checker #(.DEPTH(DEPTH)) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .txFlush  (txFlush),
  .rxPush   (rxPush),
  .rxPop    (rxPop),
  .rxFlush  (rxFlush),
  .frameErr (frameErr),
  .irqEn    (irqEn),
  .clrWrite (clrWrite),
  .clrData  (clrData),
  .txCount  (txCount),
  .rxCount  (rxCount),
  .txFull   (txFull),
  .txEmpty  (txEmpty),
  .rxFull   (rxFull),
  .irqFlags (irqFlags),
  .irq      (irq)
);

// File: tb/test_fifo_irq_ctrl.sv
`timescale 1ns/1ps
module test_fifo_irq_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txPush = 0, txPop = 0, txFlush = 0;
  logic       rxPush = 0, rxPop = 0, rxFlush = 0;
  logic       frameErr = 0, parityErr = 0;
  logic [3:0] rxThresh = 4'd0;
  logic [6:0] irqEn = 7'd0;
  logic       clrWrite = 0;
  logic [6:0] clrData = 7'd0;
  logic [3:0] txCount, rxCount;
  logic       txEmpty, txFull, rxEmpty, rxFull;
  logic [6:0] irqFlags;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fifo_irq_ctrl i_fifo_irq_ctrl (
    .clk(clk), .rstN(rstN),
    .txPush(txPush), .txPop(txPop), .txFlush(txFlush),
    .rxPush(rxPush), .rxPop(rxPop), .rxFlush(rxFlush),
    .frameErr(frameErr), .parityErr(parityErr),
    .rxThresh(rxThresh), .irqEn(irqEn),
    .clrWrite(clrWrite), .clrData(clrData),
    .txCount(txCount), .rxCount(rxCount),
    .txEmpty(txEmpty), .txFull(txFull),
    .rxEmpty(rxEmpty), .rxFull(rxFull),
    .irqFlags(irqFlags), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Inputs change at the falling edge; outputs are read one falling edge later
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clearAll();
    clrWrite = 1; clrData = 7'h7F;
    tick();
    clrWrite = 0; clrData = 7'h00;
  endtask

  task automatic txOp(input logic push, input logic pop, input int n);
    for (int i = 0; i < n; i++) begin
      txPush = push; txPop = pop;
      tick();
    end
    txPush = 0; txPop = 0;
  endtask

  task automatic rxOp(input logic push, input logic pop, input int n);
    for (int i = 0; i < n; i++) begin
      rxPush = push; rxPop = pop;
      tick();
    end
    rxPush = 0; rxPop = 0;
  endtask

  task automatic testReset();
    rxThresh = 4'd0;
    tick(); tick();
    check("R12 flags after reset", irqFlags, 7'h00);
    check("R12 tx count", txCount, 0);
    check("R12 rx count", rxCount, 0);
    check("R12 irq", irq, 0);
    check("R2 empty flags", {txEmpty, rxEmpty, txFull, rxFull}, 4'b1100);
  endtask

  task automatic testTx();
    clearAll();
    txOp(1, 0, 1);
    check("R1 tx count after push", txCount, 1);
    tick();
    check("R7 tx one flag", irqFlags, 7'h20);
    clearAll();
    txOp(1, 0, 7);
    check("R2 tx full", {txCount, txFull, txEmpty}, {4'd8, 2'b10});
    txOp(1, 0, 1);
    check("R1 push on full ignored", txCount, 8);
    txOp(1, 1, 1);
    check("R1 push+pop on full", txCount, 8);
    txOp(0, 1, 4);
    tick();
    check("R8 tx half flag", irqFlags, 7'h40);
    txOp(0, 1, 3);
    tick();
    check("R7 tx one after pops", {txCount, 1'b0, irqFlags}, {4'd1, 1'b0, 7'h60});
    txOp(0, 1, 2);
    check("R1 pop on empty ignored", {txCount, txEmpty}, {4'd0, 1'b1});
  endtask

  task automatic testRx();
    clearAll();
    rxThresh = 4'd3;
    rxOp(1, 0, 3);
    tick();
    check("R6 rx level flag", irqFlags & 7'h10, 7'h10);
    clearAll();
    rxOp(1, 0, 1);
    tick();
    check("R6 no retrigger above threshold", irqFlags & 7'h10, 7'h00);
    rxOp(1, 0, 4);
    check("R2 rx full", {rxCount, rxFull}, {4'd8, 1'b1});
    check("R4 no overrun yet", irqFlags & 7'h08, 7'h00);
    rxOp(1, 0, 1);
    check("R4 overrun flag and count", {rxCount, 1'b0, irqFlags & 7'h08}, {4'd8, 1'b0, 7'h08});
    clearAll();
    rxOp(1, 1, 1);
    check("R4 push with pop is no overrun", {rxCount, 1'b0, irqFlags & 7'h08}, {4'd8, 1'b0, 7'h00});
    rxFlush = 1; rxPush = 1;
    tick();
    rxFlush = 0; rxPush = 0;
    check("R3 rx flush beats push", {rxCount, rxEmpty}, {4'd0, 1'b1});
  endtask

  task automatic testFlushTx();
    txOp(1, 0, 3);
    txFlush = 1; txPush = 1;
    tick();
    txFlush = 0; txPush = 0;
    check("R3 tx flush beats push", txCount, 0);
  endtask

  task automatic testErrors();
    clearAll();
    frameErr = 1;
    tick();
    frameErr = 0;
    check("R5 frame flag", irqFlags, 7'h01);
    parityErr = 1;
    tick();
    parityErr = 0;
    check("R5 parity flag, bit 2 zero", irqFlags, 7'h03);
    clrWrite = 1; clrData = 7'h00;
    tick();
    clrWrite = 0;
    check("R9 write zero keeps flags", irqFlags, 7'h03);
    clrWrite = 1; clrData = 7'h01;
    tick();
    clrWrite = 0; clrData = 0;
    check("R9 write one clears bit 0 only", irqFlags, 7'h02);
    frameErr = 1; clrWrite = 1; clrData = 7'h01;
    tick();
    frameErr = 0; clrWrite = 0; clrData = 0;
    check("R10 set wins over clear", irqFlags, 7'h03);
  endtask

  task automatic testIrq();
    irqEn = 7'h00;
    #1;
    check("R11 masked irq", irq, 0);
    irqEn = 7'h02;
    #1;
    check("R11 enabled parity irq", irq, 1);
    irqEn = 7'h7C;
    #1;
    check("R11 other enables", irq, 0);
    clearAll();
    irqEn = 7'h7F;
    #1;
    check("R11 no flags no irq", irq, 0);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rstN = 1;
    testReset();
    testTx();
    testRx();
    testFlushTx();
    testErrors();
    testIrq();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule